// File: doc/BRIEF.md
# Reset Funnel Controller

This block gathers seven independent reset causes into a single system reset. The causes are a supply-voltage trip, a watchdog expiry, a stopped system clock, a comparator level trip, a software request, a conversion-start pin request and an external low level on the reset pad. Four of the causes arrive from outside the system-clock domain, so each passes through a two-flop synchronizer. The software, watchdog, missing-clock, comparator and conversion-start causes can each be switched off by software. The supply trip and the reset pad are always armed. The supply trip's arming comes only from a board strap.

Once any armed cause has gone away, the system reset is held for a fixed stretch of clock cycles. The block records the highest-priority cause of the most recent reset in a one-hot register, which only power-on reset clears. While the power-on or supply-trip phase lasts, the block drives the reset pad low. Every reset forces the clock-source select back to the internal oscillator. Software can lock the watchdog arming on, and only another power-on reset releases that lock. A missing-clock detector, running from an independent reference clock, asserts the reset asynchronously when the system clock stalls.

The block has no data stream, so there is no valid/ready interface and every pin is a plain level. Software reaches the block through a one-cycle write strobe. Address 0 holds the arming mask. Address 1 is control: bit 0 requests a software reset, bit 1 sets the watchdog lock, and bit 2 selects the external clock.

Top module: `rst_funnel`

## Requirements
- R1: Any armed cause drives `sys_rst` high. The seven causes are combined with an OR.
- R2: `sys_rst` falls exactly 32 clock cycles after the last cycle in which an armed cause is seen. A software request or a one-cycle watchdog pulse therefore gives a 32-cycle reset.
- R3: The supply trip and the reset pad cannot be masked by software. The supply trip is armed only when `supply_mon_en` is 1. `src_enable` bit 0 mirrors the strap and bit 6 always reads 1.
- R4: After power-on reset, `src_enable` reads 7'b1000011 with the strap set. In that state only the watchdog is armed among the maskable causes, and a disarmed cause never resets the system. The `src_enable` bit index of each cause is the same as its `cause_flags` bit (listed in R6).
- R5: A write to address 1 with bit 1 set locks `wdog_en` at 1. While locked, clearing bit 1 at address 0 has no effect. Only `por_n` clears the lock.
- R6: `cause_flags` is one-hot. It holds the lowest-index armed cause of the most recent reset, using these bit positions: 0 supply/power-on, 1 watchdog, 2 missing clock, 3 comparator, 4 software, 5 conversion start, 6 reset pad. Power-on reset sets it to 7'b0000001, and other resets do not clear it.
- R7: `rst_pad_oe` is high during a power-on or supply-trip reset and is low during every other reset. A low level driven onto the pad from outside gives a reset with cause bit 6.
- R8: `clk_sel_ext` is set by a write to address 1 with bit 2 set. It reads 0 whenever `sys_rst` is high, and it is still 0 after the reset releases.
- R9: With the missing-clock cause armed, if no system-clock edge occurs for 16 `ref_clk` cycles, `sys_rst` goes high without any system-clock edge.
- R10: An asynchronous cause (comparator, conversion start, supply, pad) that becomes active just after a rising edge raises `sys_rst` on the third rising edge that follows.
- R11: Configuration writes made while `sys_rst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ref_clk | input | 1 | Independent reference clock for the missing-clock detector |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_mon_en | input | 1 | Board strap that arms the supply-trip cause |
| supply_trip | input | 1 | Supply monitor trip, asynchronous, active high |
| wdog_expire | input | 1 | Watchdog timeout, system-clock domain, active high |
| cmp_trip | input | 1 | Comparator level trip, asynchronous, active high |
| cnv_rst_req | input | 1 | Conversion-start pin reset request, asynchronous, active high |
| rst_pad_in_n | input | 1 | Reset pad input level, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Write address: 0 arming mask, 1 control |
| cfg_wdata | input | 6 | Write data |
| sys_rst | output | 1 | System reset, active high |
| rst_pad_oe | output | 1 | Drives the reset pad low when high |
| clk_sel_ext | output | 1 | 1 selects the external clock source |
| wdog_en | output | 1 | Effective watchdog arming |
| src_enable | output | 7 | Effective arming of each cause |
| cause_flags | output | 7 | One-hot cause of the latest reset |

## Verification
The checker evaluates the following on every cycle:
- an armed cause is followed by reset;
- reset never releases before the stretch completes;
- the cause register stays one-hot;
- the pad is driven only inside a reset;
- the lock never falls without power-on;
- the arming mask holds still during reset;
- the clock select reads internal at release.

The bench scenarios cover the behaviours that need a scenario to show them:
- the exact reset length for each cause;
- the synchronizer latency;
- the priority between simultaneous causes;
- masked causes doing nothing;
- the stall detection with the system clock stopped, including no reset when that cause is disarmed.

// File: rtl/rf_funnel_pkg.sv
package rf_funnel_pkg;
  localparam int NUM_SRC    = 7;
  localparam int SRC_SUPPLY = 0;
  localparam int SRC_WDOG   = 1;
  localparam int SRC_MCLK   = 2;
  localparam int SRC_CMP    = 3;
  localparam int SRC_SOFT   = 4;
  localparam int SRC_CNV    = 5;
  localparam int SRC_PIN    = 6;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // lowest index wins: the supply cause has top priority
  function automatic src_vec_t first_hit(input src_vec_t v);
    src_vec_t r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rf_sync.sv
module rf_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rf_mcd.sv
module rf_mcd #(
  parameter int LIMIT  = 16,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic ref_clk,
  input  logic por_n,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          beat;
  logic          seen;
  logic          seen_d;
  logic [CW-1:0] cnt;

  // heartbeat toggles on every system-clock edge
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) beat <= 1'b0;
    else        beat <= ~beat;
  end

  rf_sync #(.WIDTH(1), .STAGES(STAGES)) i_beat_sync (
    .clk(ref_clk), .rst_n(por_n), .d(beat), .q(seen)
  );

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      seen_d <= 1'b0;
      cnt    <= '0;
      hit    <= 1'b0;
    end else begin
      seen_d <= seen;
      if (seen != seen_d) begin
        cnt <= '0;
        hit <= 1'b0;
      end else if (cnt == CW'(LIMIT - 1)) begin
        hit <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_stretch.sv
module rf_stretch #(
  parameter int CYCLES = 32
) (
  input  logic clk,
  input  logic arst,
  input  logic hold,
  output logic rst_q,
  output logic release_now
);
  localparam int CW = $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt   <= '0;
      rst_q <= 1'b1;
    end else if (hold) begin
      cnt   <= '0;
      rst_q <= 1'b1;
    end else if (rst_q) begin
      if (cnt == LAST) rst_q <= 1'b0;
      else             cnt   <= cnt + 1'b1;
    end
  end

  assign release_now = rst_q & ~hold & (cnt == LAST);
endmodule

// File: rtl/rf_cfg.sv
module rf_cfg
  import rf_funnel_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst,
  input  logic             strap,
  input  logic             wr,
  input  logic             addr,
  input  logic [NUM_SRC-2:0] wdata,
  output src_vec_t         src_en,
  output logic             wdog_lock,
  output logic             sw_req,
  output logic             clk_sel_ext
);
  localparam logic [NUM_SRC-2:1] EN_DEFAULT = (NUM_SRC-2)'(1);  // watchdog only

  logic [NUM_SRC-2:1] en_q;
  logic               sel_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q      <= EN_DEFAULT;
      wdog_lock <= 1'b0;
      sw_req    <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      sw_req <= 1'b0;
      if (sys_rst) begin
        sel_q <= 1'b0;
      end else if (wr) begin
        if (!addr) begin
          en_q <= wdata[NUM_SRC-2:1];
        end else begin
          sw_req    <= wdata[0];
          wdog_lock <= wdog_lock | wdata[1];
          sel_q     <= wdata[2];
        end
      end
    end
  end

  always_comb begin
    src_en             = '0;
    src_en[NUM_SRC-2:1] = en_q;
    src_en[SRC_WDOG]   = en_q[SRC_WDOG] | wdog_lock;
    src_en[SRC_SUPPLY] = strap;
    src_en[SRC_PIN]    = 1'b1;
  end

  assign clk_sel_ext = sel_q & ~sys_rst;
endmodule

// File: rtl/rst_funnel.sv
module rst_funnel
  import rf_funnel_pkg::*;
#(
  parameter int STRETCH_CYCLES = 32,
  parameter int MCD_LIMIT      = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               ref_clk,
  input  logic               por_n,
  input  logic               supply_mon_en,
  input  logic               supply_trip,
  input  logic               wdog_expire,
  input  logic               cmp_trip,
  input  logic               cnv_rst_req,
  input  logic               rst_pad_in_n,
  input  logic               cfg_wr,
  input  logic               cfg_addr,
  input  logic [NUM_SRC-2:0] cfg_wdata,
  output logic               sys_rst,
  output logic               rst_pad_oe,
  output logic               clk_sel_ext,
  output logic               wdog_en,
  output logic [NUM_SRC-1:0] src_enable,
  output logic [NUM_SRC-1:0] cause_flags
);
  localparam int NUM_ASYNC = 5;

  logic [NUM_ASYNC-1:0] async_raw;
  logic [NUM_ASYNC-1:0] async_q;
  logic                 mcd_hit;
  logic                 sw_req;
  logic                 wdog_lock;
  logic                 release_now;
  logic                 arst;
  logic                 por_phase;
  logic [SYNC_STAGES-1:0] oe_hist;
  logic                 pin_blank;
  src_vec_t             src_en;
  src_vec_t             src_raw;
  src_vec_t             src_hit;

  rf_mcd #(.LIMIT(MCD_LIMIT), .STAGES(SYNC_STAGES)) i_mcd (
    .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .hit(mcd_hit)
  );

  assign async_raw = {~rst_pad_in_n, cnv_rst_req, cmp_trip, mcd_hit, supply_trip};

  rf_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) i_src_sync (
    .clk(clk), .rst_n(por_n), .d(async_raw), .q(async_q)
  );

  rf_cfg i_cfg (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .strap(supply_mon_en),
    .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .src_en(src_en), .wdog_lock(wdog_lock), .sw_req(sw_req),
    .clk_sel_ext(clk_sel_ext)
  );

  // the pad reads back its own drive; ignore it until the synchronizer has flushed
  assign pin_blank = por_phase | (|oe_hist);

  always_comb begin
    src_raw             = '0;
    src_raw[SRC_SUPPLY] = async_q[0];
    src_raw[SRC_WDOG]   = wdog_expire;
    src_raw[SRC_MCLK]   = async_q[1];
    src_raw[SRC_CMP]    = async_q[2];
    src_raw[SRC_SOFT]   = sw_req;
    src_raw[SRC_CNV]    = async_q[3];
    src_raw[SRC_PIN]    = async_q[4] & ~pin_blank;
  end

  assign src_hit = src_raw & src_en;

  // a stalled clock cannot clock the reset in, so that cause bypasses the flops
  assign arst = ~por_n | (mcd_hit & src_en[SRC_MCLK]);

  rf_stretch #(.CYCLES(STRETCH_CYCLES)) i_stretch (
    .clk(clk), .arst(arst), .hold(|src_hit),
    .rst_q(sys_rst), .release_now(release_now)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_phase   <= 1'b1;
      oe_hist     <= '1;
      cause_flags <= src_vec_t'(1) << SRC_SUPPLY;
    end else begin
      if (src_hit[SRC_SUPPLY]) por_phase <= 1'b1;
      else if (release_now)    por_phase <= 1'b0;
      oe_hist <= (oe_hist << 1) | SYNC_STAGES'(por_phase);
      if (|src_hit) cause_flags <= first_hit(src_hit);
    end
  end

  assign rst_pad_oe = por_phase;
  assign wdog_en    = src_en[SRC_WDOG];
  assign src_enable = src_en;
endmodule

// File: rtl/rf_funnel_chk.sv
module rf_funnel_chk #(
  parameter int STRETCH = 32,
  parameter int NSRC    = 7
) (
  input logic            clk,
  input logic            por_n,
  input logic            sys_rst,
  input logic            rst_pad_oe,
  input logic            clk_sel_ext,
  input logic            wdog_en,
  input logic            wdog_lock,
  input logic [NSRC-1:0] src_hit,
  input logic [NSRC-1:0] src_enable,
  input logic [NSRC-1:0] cause_flags
);
  localparam int CW = $clog2(STRETCH + 2);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          hi_cnt <= '0;
    else if (!sys_rst)                   hi_cnt <= '0;
    else if (hi_cnt != CW'(STRETCH + 1)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_hit_resets_R1: assert property (@(posedge clk) disable iff (!por_n)
    (|src_hit) |=> sys_rst);

  assert_stretch_min_R2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (hi_cnt >= CW'(STRETCH)));

  assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!por_n)
    $past(wdog_lock) |-> wdog_lock);

  assert_lock_arms_R5: assert property (@(posedge clk) disable iff (!por_n)
    wdog_lock |-> wdog_en);

  assert_cause_onehot_R6: assert property (@(posedge clk) disable iff (!por_n)
    $countones(cause_flags) == 1);

  assert_pad_in_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
    rst_pad_oe |-> sys_rst);

  assert_clksel_released_R8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> !clk_sel_ext);

  assert_mask_frozen_R11: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> $stable(src_enable[NSRC-2:1]));
endmodule

bind rst_funnel rf_funnel_chk #(.STRETCH(STRETCH_CYCLES), .NSRC(rf_funnel_pkg::NUM_SRC)) i_chk (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .rst_pad_oe(rst_pad_oe),
  .clk_sel_ext(clk_sel_ext), .wdog_en(wdog_en), .wdog_lock(wdog_lock),
  .src_hit(src_hit), .src_enable(src_enable), .cause_flags(cause_flags)
);

// File: tb/test_rst_funnel.sv
`timescale 1ns/1ps
module test_rst_funnel;
  typedef struct packed {
    logic [6:0]  cause;
    logic [15:0] len;
  } rst_ev_t;

  localparam logic [15:0] ANY_LEN = 16'hFFFF;

  logic clk = 1'b0, ref_clk = 1'b0, clk_run = 1'b1;
  logic por_n = 1'b1, supply_mon_en = 1'b1, supply_trip = 1'b0;
  logic wdog_expire = 1'b0, cmp_trip = 1'b0, cnv_rst_req = 1'b0, ext_pull = 1'b0;
  logic cfg_wr = 1'b0, cfg_addr = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic sys_rst, rst_pad_oe, clk_sel_ext, wdog_en;
  logic [6:0] src_enable, cause_flags;
  logic rst_pad_in_n;

  int checks = 0, failures = 0;
  rst_ev_t exp_q[$];
  int run_len = 0;

  assign rst_pad_in_n = ~(rst_pad_oe | ext_pull);

  always begin
    #4;
    if (clk_run) clk = ~clk;
  end
  always #10 ref_clk = ~ref_clk;

  rst_funnel i_rst_funnel (
    .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .supply_mon_en(supply_mon_en),
    .supply_trip(supply_trip), .wdog_expire(wdog_expire), .cmp_trip(cmp_trip),
    .cnv_rst_req(cnv_rst_req), .rst_pad_in_n(rst_pad_in_n), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sys_rst(sys_rst),
    .rst_pad_oe(rst_pad_oe), .clk_sel_ext(clk_sel_ext), .wdog_en(wdog_en),
    .src_enable(src_enable), .cause_flags(cause_flags)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rst(input logic [6:0] cause, input logic [15:0] len);
    rst_ev_t e;
    e.cause = cause;
    e.len   = len;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic a, input logic [5:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_release();
    @(negedge clk);
    while (sys_rst) @(negedge clk);
    cyc(2);
  endtask

  // monitor: measures every reset pulse and scores it against the queue
  always @(negedge clk) begin
    if (sys_rst) begin
      run_len++;
    end else if (run_len > 0) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected reset", run_len, 0);
      end else begin
        rst_ev_t e;
        e = exp_q.pop_front();
        chk(cause_flags == e.cause, "R6 cause of reset", int'(cause_flags), int'(e.cause));
        if (e.len != ANY_LEN)
          chk(run_len == int'(e.len), "R2 reset length", run_len, int'(e.len));
      end
      run_len = 0;
    end
  end

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // power-on
    expect_rst(7'b0000001, ANY_LEN);
    #2 por_n = 1'b0;
    cyc(4);
    chk(rst_pad_oe == 1'b1, "R7 pad driven in power-on", int'(rst_pad_oe), 1);
    chk(sys_rst == 1'b1, "R1 reset during power-on", int'(sys_rst), 1);
    por_n = 1'b1;
    wait_release();
    chk(cause_flags == 7'b0000001, "R6 power-on cause", int'(cause_flags), 1);
    chk(src_enable == 7'b1000011, "R4 default arming", int'(src_enable), 'h43);
    chk(wdog_en == 1'b1, "R4 watchdog armed by default", int'(wdog_en), 1);
    chk(rst_pad_oe == 1'b0, "R7 pad released", int'(rst_pad_oe), 0);
    chk(clk_sel_ext == 1'b0, "R8 internal clock after reset", int'(clk_sel_ext), 0);

    // disarmed comparator does nothing
    cmp_trip = 1'b1;
    cyc(6);
    chk(sys_rst == 1'b0, "R4 masked comparator ignored", int'(sys_rst), 0);
    cmp_trip = 1'b0;
    cyc(3);
    chk(cause_flags == 7'b0000001, "R4 cause untouched by masked source", int'(cause_flags), 1);

    // arm everything maskable
    wr(1'b0, 6'b111110);
    chk(src_enable == 7'b1111111, "R3 arming readback", int'(src_enable), 'h7F);
    wr(1'b1, 6'b000100);
    chk(clk_sel_ext == 1'b1, "R8 external clock selected", int'(clk_sel_ext), 1);

    // software reset, with writes during reset
    expect_rst(7'b0010000, 16'd32);
    wr(1'b1, 6'b000101);
    @(negedge clk);
    chk(sys_rst == 1'b1, "R1 software reset asserted", int'(sys_rst), 1);
    chk(clk_sel_ext == 1'b0, "R8 clock select forced in reset", int'(clk_sel_ext), 0);
    chk(rst_pad_oe == 1'b0, "R7 pad idle in software reset", int'(rst_pad_oe), 0);
    wr(1'b1, 6'b000100);
    wr(1'b0, 6'b000000);
    wait_release();
    chk(clk_sel_ext == 1'b0, "R11 clock write in reset ignored", int'(clk_sel_ext), 0);
    chk(src_enable == 7'b1111111, "R11 arming write in reset ignored", int'(src_enable), 'h7F);

    // comparator latency through the synchronizer
    expect_rst(7'b0001000, 16'd36);
    cmp_trip = 1'b1;
    cyc(2);
    chk(sys_rst == 1'b0, "R10 no reset before third edge", int'(sys_rst), 0);
    cyc(1);
    chk(sys_rst == 1'b1, "R10 reset on third edge", int'(sys_rst), 1);
    cyc(2);
    cmp_trip = 1'b0;
    wait_release();

    // simultaneous comparator and conversion start: lower index wins
    expect_rst(7'b0001000, 16'd36);
    cmp_trip = 1'b1; cnv_rst_req = 1'b1;
    cyc(5);
    cmp_trip = 1'b0; cnv_rst_req = 1'b0;
    wait_release();
    expect_rst(7'b0100000, 16'd34);
    cnv_rst_req = 1'b1;
    cyc(3);
    cnv_rst_req = 1'b0;
    wait_release();

    // watchdog pulse
    expect_rst(7'b0000010, 16'd32);
    wdog_expire = 1'b1;
    cyc(1);
    wdog_expire = 1'b0;
    wait_release();

    // watchdog disarm, then lock
    wr(1'b0, 6'b111100);
    chk(wdog_en == 1'b0, "R5 watchdog disarmed before lock", int'(wdog_en), 0);
    wdog_expire = 1'b1;
    cyc(1);
    wdog_expire = 1'b0;
    cyc(3);
    chk(sys_rst == 1'b0, "R4 disarmed watchdog ignored", int'(sys_rst), 0);
    wr(1'b1, 6'b000010);
    chk(wdog_en == 1'b1, "R5 lock arms watchdog", int'(wdog_en), 1);
    wr(1'b0, 6'b000000);
    chk(wdog_en == 1'b1, "R5 locked watchdog stays armed", int'(wdog_en), 1);
    expect_rst(7'b0000010, 16'd32);
    wdog_expire = 1'b1;
    cyc(1);
    wdog_expire = 1'b0;
    wait_release();
    chk(wdog_en == 1'b1, "R5 lock survives watchdog reset", int'(wdog_en), 1);

    // supply trip, strap off then on
    supply_mon_en = 1'b0;
    cyc(1);
    chk(src_enable[0] == 1'b0, "R3 supply arming follows strap", int'(src_enable[0]), 0);
    supply_trip = 1'b1;
    cyc(4);
    supply_trip = 1'b0;
    cyc(3);
    chk(sys_rst == 1'b0, "R3 supply ignored with strap off", int'(sys_rst), 0);
    supply_mon_en = 1'b1;
    expect_rst(7'b0000001, 16'd35);
    supply_trip = 1'b1;
    cyc(4);
    supply_trip = 1'b0;
    chk(rst_pad_oe == 1'b1, "R7 pad driven in supply reset", int'(rst_pad_oe), 1);
    wait_release();
    chk(rst_pad_oe == 1'b0, "R7 pad released after supply reset", int'(rst_pad_oe), 0);

    // external pad, all maskable causes off (mask was cleared above)
    expect_rst(7'b1000000, 16'd35);
    ext_pull = 1'b1;
    cyc(4);
    chk(rst_pad_oe == 1'b0, "R7 pad not driven for external reset", int'(rst_pad_oe), 0);
    ext_pull = 1'b0;
    wait_release();

    // missing clock, armed
    wr(1'b0, 6'b111110);
    expect_rst(7'b0000100, ANY_LEN);
    @(negedge clk);
    clk_run = 1'b0;
    #600;
    chk(sys_rst == 1'b1, "R9 stalled clock resets", int'(sys_rst), 1);
    clk_run = 1'b1;
    wait_release();

    // missing clock, disarmed
    wr(1'b0, 6'b111010);
    @(negedge clk);
    clk_run = 1'b0;
    #600;
    chk(sys_rst == 1'b0, "R9 disarmed stall ignored", int'(sys_rst), 0);
    clk_run = 1'b1;
    cyc(10);
    chk(sys_rst == 1'b0, "R9 no reset after resume", int'(sys_rst), 0);

    // second power-on clears lock
    expect_rst(7'b0000001, ANY_LEN);
    @(negedge clk);
    por_n = 1'b0;
    cyc(3);
    por_n = 1'b1;
    wait_release();
    chk(cause_flags == 7'b0000001, "R6 power-on cause again", int'(cause_flags), 1);
    wr(1'b0, 6'b000000);
    chk(wdog_en == 1'b0, "R5 lock cleared by power-on", int'(wdog_en), 0);
    chk(src_enable == 7'b1000001, "R3 fixed sources stay armed", int'(src_enable), 'h41);

    cyc(4);
    chk(exp_q.size() == 0, "R1 all expected resets seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule